// File: doc/BRIEF.md
# Programmable PLL Divider Chain

This block holds the three digital dividers that sit around a clock-multiplying PLL. The reference divider slows the incoming reference clock. The feedback divider slows the clock that returns from the loop. Both feed a phase comparator, so each one emits a one-cycle terminal-count pulse. The output divider follows the VCO and produces the clock that leaves the chip. The analog loop itself is outside the block. The three clocks arrive as ordinary digital inputs.

Static configuration words set the ratios. The reference and feedback paths each take a 7-bit word and divide by that word plus two. Each path can also double its ratio through a prescale bit. The output path takes a 2-bit select. An active-low power-down input stops every divider and drops the output enable. When power-down is released, all counters restart together, so the reference and feedback pulses begin aligned. A new word is taken at a terminal count and never in the middle of a period. Each divider also gives a squared-up clock whose high time is half its period, for odd ratios as well as even ones.

Top module: `pll_div_chain`

## Requirements
- R1: With `refPre`=0, `refTc` pulses once every `refWord`+2 cycles of `clkRef`, and each pulse lasts one cycle.
- R2: With `refPre`=1, the reference period becomes 2×(`refWord`+2) cycles.
- R3: `fbTc` follows the same rule as R1/R2 on `clkFb`, using `fbWord` and `fbPre`, independently of the reference settings.
- R4: `outSel` 2'b00, 2'b01 and 2'b10 divide `clkVco` by 2, 4 and 8. `outTc` pulses once per period.
- R5: `outSel`=2'b11 bypasses the divider: `outClk` follows `clkVco` while enabled, and `outTc` is high on every cycle.
- R6: Each squared clock (`refClk`, `fbClk`, `outClk`) is high for exactly T of the 2T half-cycles in a period of T input cycles. For odd T, a flop on the falling edge extends the high time by half a cycle.
- R7: Whenever a terminal-count pulse is high, the squared clock of the same divider is high in that cycle. The pulse marks the clock's rising edge.
- R8: A word change takes effect only at the next terminal count. The period that is running completes with the old ratio.
- R9: While `pdN` is low, all terminal-count pulses and squared clocks are low. `oe` follows `pdN` at each falling edge of `clkVco`.
- R10: On the first clock edge that samples `pdN` high, every divider issues its terminal-count pulse, and counting then restarts from zero. Dividers that share a clock therefore pulse in the same cycle.
- R11: While `rstN` is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkRef | input | 1 | Reference clock into the reference divider |
| clkFb | input | 1 | Loop clock into the feedback divider |
| clkVco | input | 1 | VCO clock into the output divider |
| rstN | input | 1 | Asynchronous reset, active low |
| pdN | input | 1 | Power-down, active low |
| refWord | input | 7 | Reference ratio word; ratio is word+2 |
| refPre | input | 1 | Doubles the reference ratio when 1 |
| fbWord | input | 7 | Feedback ratio word; ratio is word+2 |
| fbPre | input | 1 | Doubles the feedback ratio when 1 |
| outSel | input | 2 | Output ratio: 00 /2, 01 /4, 10 /8, 11 pass-through |
| refTc | output | 1 | Reference terminal-count pulse |
| refClk | output | 1 | Squared reference-divided clock |
| fbTc | output | 1 | Feedback terminal-count pulse |
| fbClk | output | 1 | Squared feedback-divided clock |
| outTc | output | 1 | Output-divider terminal-count pulse |
| outClk | output | 1 | Divided or bypassed VCO clock |
| oe | output | 1 | Output enable, low during power-down |

## Verification
The bench builds the block with its default parameters: a 7-bit word, an offset of two and a 9-bit counter. With these values, both ends of the ratio range can be reached in a few hundred cycles. The smallest ratio is 2, and the largest is 258, which is word 127 with the prescaler on. Odd ratios such as 3, 5, 7 and 129 test the falling-edge extension. All three clock inputs share one bench clock, so the release alignment across dividers can be seen directly. A reload in the middle of a period shows whether a word is taken early.

// File: rtl/pll_div_pkg.sv
`timescale 1ns/1ps
package pll_div_pkg;

  // Strobes handed from a divider's control to its datapath.
  typedef struct packed {
    logic hold;   // power-down: park counter, silence outputs
    logic load;   // take a fresh ratio this edge
  } divStrobe_t;

  // Output divider select codes; 2'b11 is pass-through.
  typedef enum logic [1:0] {
    OD_DIV2 = 2'b00,
    OD_DIV4 = 2'b01,
    OD_DIV8 = 2'b10,
    OD_PASS = 2'b11
  } odSel_e;

  localparam int NUM_DIV = 3;
  localparam int IDX_REF = 0;
  localparam int IDX_FB  = 1;
  localparam int IDX_OUT = 2;

  function automatic int unsigned odRatio(input odSel_e s);
    case (s)
      OD_DIV2: return 2;
      OD_DIV4: return 4;
      OD_DIV8: return 8;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/pll_div_ctrl.sv
`timescale 1ns/1ps
module pll_div_ctrl
  import pll_div_pkg::*;
#(
  parameter int               CNT_W    = 9,
  parameter logic [CNT_W-1:0] RST_LAST = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pdN,
  input  logic [CNT_W-1:0] lastCfg,
  input  logic             atLast,
  output divStrobe_t       stb,
  output logic [CNT_W-1:0] lastCur,
  output logic [CNT_W-1:0] lastUse
);

  // A fresh ratio is accepted only at a terminal count or while parked,
  // so a running period is never cut short.
  always_comb begin
    stb.hold = ~pdN;
    stb.load = ~pdN | atLast;
    lastUse  = stb.load ? lastCfg : lastCur;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastCur <= RST_LAST;
    else       lastCur <= lastUse;
  end

endmodule

// File: rtl/pll_div_dp.sv
`timescale 1ns/1ps
module pll_div_dp
  import pll_div_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobe_t       stb,
  input  logic [CNT_W-1:0] lastCur,
  input  logic [CNT_W-1:0] lastUse,
  output logic             atLast,
  output logic             tc,
  output logic             sq
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] halfNext;
  logic [CNT_W:0]   periodNext;
  logic             posHi;
  logic             negHi;
  logic             oddReg;

  // ">=" rather than "==" so a parked (all-ones) count wraps at once.
  assign atLast = (cnt >= lastCur);

  always_comb begin
    if (stb.hold)    cntNext = '1;
    else if (atLast) cntNext = '0;
    else             cntNext = cnt + CNT_W'(1);
    periodNext = {1'b0, lastUse} + (CNT_W+1)'(1);
    halfNext   = periodNext[CNT_W:1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '1;
      tc     <= 1'b0;
      posHi  <= 1'b0;
      oddReg <= 1'b0;
    end else begin
      cnt   <= cntNext;
      tc    <= ~stb.hold & atLast;
      posHi <= ~stb.hold & (cntNext < halfNext);
      if (stb.load) oddReg <= ~lastUse[0];
    end
  end

  // Half-cycle helper: delays the high phase so odd periods reach 50%.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) negHi <= 1'b0;
    else       negHi <= posHi;
  end

  assign sq = posHi | (negHi & oddReg);

endmodule

// File: rtl/pll_div_chain.sv
`timescale 1ns/1ps
module pll_div_chain
  import pll_div_pkg::*;
#(
  parameter int WORD_W = 7,
  parameter int OFFSET = 2
) (
  input  logic              clkRef,
  input  logic              clkFb,
  input  logic              clkVco,
  input  logic              rstN,
  input  logic              pdN,
  input  logic [WORD_W-1:0] refWord,
  input  logic              refPre,
  input  logic [WORD_W-1:0] fbWord,
  input  logic              fbPre,
  input  logic [1:0]        outSel,
  output logic              refTc,
  output logic              refClk,
  output logic              fbTc,
  output logic              fbClk,
  output logic              outTc,
  output logic              outClk,
  output logic              oe
);

  localparam int PROG_MAX_T = ((2 ** WORD_W) - 1 + OFFSET) * 2;
  localparam int CNT_W      = $clog2(PROG_MAX_T + 1);
  localparam logic [CNT_W-1:0] PROG_RST_LAST = CNT_W'(PROG_MAX_T - 1);
  localparam logic [CNT_W-1:0] OUT_RST_LAST  = CNT_W'(0);

  function automatic logic [CNT_W-1:0] progLast(input logic [WORD_W-1:0] w,
                                                input logic pre);
    logic [CNT_W-1:0] base;
    base = CNT_W'(w) + CNT_W'(OFFSET);
    return pre ? ((base << 1) - CNT_W'(1)) : (base - CNT_W'(1));
  endfunction

  logic             clkArr     [NUM_DIV];
  logic [CNT_W-1:0] lastCfgArr [NUM_DIV];
  logic [CNT_W-1:0] lastCurArr [NUM_DIV];
  logic [CNT_W-1:0] lastUseArr [NUM_DIV];
  logic [NUM_DIV-1:0] tcArr;
  logic [NUM_DIV-1:0] sqArr;
  logic             bypass;

  assign clkArr[IDX_REF] = clkRef;
  assign clkArr[IDX_FB]  = clkFb;
  assign clkArr[IDX_OUT] = clkVco;

  always_comb begin
    lastCfgArr[IDX_REF] = progLast(refWord, refPre);
    lastCfgArr[IDX_FB]  = progLast(fbWord, fbPre);
    lastCfgArr[IDX_OUT] = CNT_W'(odRatio(odSel_e'(outSel)) - 1);
  end

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    localparam logic [CNT_W-1:0] RST_LAST =
      (g == IDX_OUT) ? OUT_RST_LAST : PROG_RST_LAST;
    divStrobe_t stb;
    logic       atLast;

    pll_div_ctrl #(.CNT_W(CNT_W), .RST_LAST(RST_LAST)) u_ctrl (
      .clk     (clkArr[g]),
      .rstN    (rstN),
      .pdN     (pdN),
      .lastCfg (lastCfgArr[g]),
      .atLast  (atLast),
      .stb     (stb),
      .lastCur (lastCurArr[g]),
      .lastUse (lastUseArr[g])
    );

    pll_div_dp #(.CNT_W(CNT_W)) u_dp (
      .clk     (clkArr[g]),
      .rstN    (rstN),
      .stb     (stb),
      .lastCur (lastCurArr[g]),
      .lastUse (lastUseArr[g]),
      .atLast  (atLast),
      .tc      (tcArr[g]),
      .sq      (sqArr[g])
    );
  end

  // Enable changes on the falling edge, while clkVco is low, so the
  // bypass gate below never produces a partial high pulse.
  always_ff @(negedge clkVco or negedge rstN) begin
    if (!rstN) oe <= 1'b0;
    else       oe <= pdN;
  end

  assign bypass = (lastCurArr[IDX_OUT] == '0);

  assign refTc  = tcArr[IDX_REF];
  assign refClk = sqArr[IDX_REF];
  assign fbTc   = tcArr[IDX_FB];
  assign fbClk  = sqArr[IDX_FB];
  assign outTc  = tcArr[IDX_OUT];
  assign outClk = bypass ? (clkVco & oe) : sqArr[IDX_OUT];

endmodule

// File: rtl/pll_div_chain_chk.sv
`timescale 1ns/1ps
module pll_div_chain_chk (
  input logic clkRef,
  input logic clkFb,
  input logic clkVco,
  input logic rstN,
  input logic pdN,
  input logic refTc,
  input logic refClk,
  input logic fbTc,
  input logic fbClk,
  input logic oe
);

  p_ref_tc_one_cycle_r1: assert property (@(posedge clkRef) disable iff (!rstN || !pdN)
    refTc |=> !refTc);

  p_fb_tc_one_cycle_r3: assert property (@(posedge clkFb) disable iff (!rstN || !pdN)
    fbTc |=> !fbTc);

  p_ref_tc_on_rise_r7: assert property (@(posedge clkRef) disable iff (!rstN)
    refTc |-> refClk);

  p_fb_tc_on_rise_r7: assert property (@(posedge clkFb) disable iff (!rstN)
    fbTc |-> fbClk);

  p_pd_ref_quiet_r9: assert property (@(posedge clkRef) disable iff (!rstN)
    !pdN |=> !refTc);

  p_pd_fb_quiet_r9: assert property (@(posedge clkFb) disable iff (!rstN)
    !pdN |=> !fbTc);

  p_oe_drop_r9: assert property (@(negedge clkVco) disable iff (!rstN)
    !pdN |=> !oe);

  p_oe_raise_r9: assert property (@(negedge clkVco) disable iff (!rstN)
    pdN |=> oe);

  p_ref_restart_r10: assert property (@(posedge clkRef) disable iff (!rstN)
    $rose(pdN) |=> refTc);

  p_fb_restart_r10: assert property (@(posedge clkFb) disable iff (!rstN)
    $rose(pdN) |=> fbTc);

endmodule

bind pll_div_chain pll_div_chain_chk i_chk (
  .clkRef (clkRef),
  .clkFb  (clkFb),
  .clkVco (clkVco),
  .rstN   (rstN),
  .pdN    (pdN),
  .refTc  (refTc),
  .refClk (refClk),
  .fbTc   (fbTc),
  .fbClk  (fbClk),
  .oe     (oe)
);

// File: tb/test_pll_div_chain.sv
`timescale 1ns/1ps
module test_pll_div_chain;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN, pdN, refPre, fbPre;
  logic [6:0] refWord, fbWord;
  logic [1:0] outSel;
  logic       refTc, refClk, fbTc, fbClk, outTc, outClk, oe;

  pll_div_chain i_pll_div_chain (
    .clkRef (clk), .clkFb (clk), .clkVco (clk),
    .rstN (rstN), .pdN (pdN),
    .refWord (refWord), .refPre (refPre),
    .fbWord (fbWord), .fbPre (fbPre), .outSel (outSel),
    .refTc (refTc), .refClk (refClk), .fbTc (fbTc), .fbClk (fbClk),
    .outTc (outTc), .outClk (outClk), .oe (oe)
  );

  typedef struct packed {
    logic [6:0] rw;
    logic       rp;
    logic [6:0] fw;
    logic       fp;
    logic [1:0] sel;
    logic [9:0] eRef;
    logic [9:0] eFb;
    logic [9:0] eOut;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{7'd0,   1'b0, 7'd1,   1'b0, 2'b00, 10'd2,   10'd3,   10'd2},
    '{7'd3,   1'b1, 7'd0,   1'b1, 2'b01, 10'd10,  10'd4,   10'd4},
    '{7'd127, 1'b0, 7'd127, 1'b1, 2'b10, 10'd129, 10'd258, 10'd8},
    '{7'd5,   1'b0, 7'd2,   1'b0, 2'b10, 10'd7,   10'd4,   10'd8},
    '{7'd2,   1'b0, 7'd3,   1'b0, 2'b00, 10'd4,   10'd5,   10'd2},
    '{7'd126, 1'b1, 7'd10,  1'b0, 2'b11, 10'd256, 10'd12,  10'd1}
  };

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int t1 [3];
  int t2 [3];
  int hi [3];
  int sqAtTc [3];
  int oeAt0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic parkAndSet(input vec_t v);
    @(posedge clk); #2;
    pdN = 1'b0;
    refWord = v.rw; refPre = v.rp;
    fbWord = v.fw;  fbPre = v.fp;
    outSel = v.sel;
    repeat (2) @(posedge clk);
  endtask

  task automatic releasePd();
    @(posedge clk); #2;
    pdN = 1'b1;
  endtask

  // Cycle c is observed 1 ns after the c-th rising edge since release.
  task automatic measure(input int ncyc);
    int n [3];
    logic [2:0] tcs, sqs;
    for (int i = 0; i < 3; i++) begin
      t1[i] = -1; t2[i] = -1; hi[i] = 0; n[i] = 0; sqAtTc[i] = -1;
    end
    oeAt0 = -1;
    for (int c = 0; c < ncyc; c++) begin
      @(posedge clk); #1;
      tcs = {outTc, fbTc, refTc};
      sqs = {outClk, fbClk, refClk};
      if (c == 0) oeAt0 = int'(oe);
      for (int i = 0; i < 3; i++) begin
        if (tcs[i]) begin
          if (n[i] == 0) begin
            t1[i] = c; sqAtTc[i] = int'(sqs[i]); n[i] = 1;
          end else if (n[i] == 1) begin
            t2[i] = c; n[i] = 2;
          end
        end
        if (n[i] == 1 && sqs[i]) hi[i]++;
      end
      @(negedge clk); #1;
      sqs = {outClk, fbClk, refClk};
      for (int i = 0; i < 3; i++)
        if (n[i] == 1 && sqs[i]) hi[i]++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int tcAt [3];
    int nTc;
    rstN = 1'b0; pdN = 1'b1;
    refWord = '1; refPre = 1'b1; fbWord = '1; fbPre = 1'b1; outSel = 2'b11;

    // R11: every output low while held in reset
    repeat (3) begin
      @(posedge clk); #1;
      chk("R11", "refTc in reset", int'(refTc), 0);
      chk("R11", "fbTc in reset", int'(fbTc), 0);
      chk("R11", "outTc in reset", int'(outTc), 0);
      chk("R11", "refClk in reset", int'(refClk), 0);
      chk("R11", "fbClk in reset", int'(fbClk), 0);
      chk("R11", "outClk in reset", int'(outClk), 0);
      chk("R11", "oe in reset", int'(oe), 0);
    end
    @(posedge clk); #2;
    rstN = 1'b1;
    repeat (5) @(posedge clk);

    // Table walk: ratios (R1..R5), half-cycle duty (R6), tc at rise (R7),
    // enable (R9) and aligned restart (R10)
    for (int v = 0; v < NV; v++) begin
      int expT [3];
      int maxT;
      string perTag [3];
      expT[0] = int'(VECS[v].eRef);
      expT[1] = int'(VECS[v].eFb);
      expT[2] = int'(VECS[v].eOut);
      perTag[0] = VECS[v].rp ? "R2" : "R1";
      perTag[1] = "R3";
      perTag[2] = (VECS[v].sel == 2'b11) ? "R5" : "R4";
      maxT = expT[0];
      if (expT[1] > maxT) maxT = expT[1];
      if (expT[2] > maxT) maxT = expT[2];
      parkAndSet(VECS[v]);
      releasePd();
      measure(maxT + 3);
      chk("R9", "oe after release", oeAt0, 1);
      for (int i = 0; i < 3; i++) begin
        chk("R10", $sformatf("vec %0d div %0d first pulse cycle", v, i), t1[i], 0);
        chk(perTag[i], $sformatf("vec %0d div %0d period", v, i), t2[i] - t1[i], expT[i]);
        chk("R6", $sformatf("vec %0d div %0d high half-cycles", v, i), hi[i], expT[i]);
        chk("R7", $sformatf("vec %0d div %0d clock at pulse", v, i), sqAtTc[i], 1);
      end
    end

    // R9: power-down silences everything (last vector left bypass selected)
    @(posedge clk); #2;
    pdN = 1'b0;
    repeat (2) @(posedge clk);
    repeat (4) begin
      @(posedge clk); #1;
      chk("R9", "refTc parked", int'(refTc), 0);
      chk("R9", "fbTc parked", int'(fbTc), 0);
      chk("R9", "outTc parked", int'(outTc), 0);
      chk("R9", "refClk parked", int'(refClk), 0);
      chk("R9", "fbClk parked", int'(fbClk), 0);
      chk("R9", "outClk parked high phase", int'(outClk), 0);
      chk("R9", "oe parked", int'(oe), 0);
      @(negedge clk); #1;
      chk("R9", "outClk parked low phase", int'(outClk), 0);
    end

    // R8: word change mid-period waits for the terminal count
    refWord = 7'd6; refPre = 1'b0;
    repeat (2) @(posedge clk);
    releasePd();
    nTc = 0;
    for (int i = 0; i < 3; i++) tcAt[i] = -1;
    for (int c = 0; c < 20; c++) begin
      @(posedge clk); #1;
      if (refTc && nTc < 3) begin
        tcAt[nTc] = c; nTc++;
      end
      @(negedge clk); #1;
      if (c == 2) refWord = 7'd2;
    end
    chk("R8", "first pulse after release", tcAt[0], 0);
    chk("R8", "old ratio kept to terminal count", tcAt[1], 8);
    chk("R8", "new ratio after terminal count", tcAt[2], 12);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule